// File: doc/BRIEF.md
# Learning-Phase Stack Mapping Analyzer

This block watches the memory traffic of offloaded code regions during a bounded learning window and works out, for each memory allocation, which of four address-bit stack mappings would most often place the touched data in the same memory stack as the code that touched it. Software loads up to eight allocation ranges (base and size) before launch, sets an instance limit, and pulses a start input. Each access event carries a region instance ID, an address and the stack the issuing code runs on.

Each event is matched to an allocation, and the offset inside it is scored under every candidate mapping. When the number of distinct region instances reaches the programmed limit, learning stops. The winning mapping of every allocation is then latched into that allocation's entry, and an interrupt tells the driver that the bulk data copy can proceed. Software reads the choices back through a small indexed read port and clears the interrupt with a one-cycle pulse.

Top module: `map_learn_analyzer`

## Requirements
- R1: After reset, learning_o, irq_o and reg_map_o (for every reg_addr_i) are 0.
- R2: A table write stores base and size at tbl_idx_i. A size of 0 marks the entry unused. An event matches entry i when base <= addr and addr - base < size. When ranges overlap, the lowest matching index wins. An event that matches no entry changes no score.
- R3: Candidate mapping m (0..3) takes stack = bits [13+m:12+m] of the offset addr - base. For a matched entry, the score of mapping m goes up by one exactly when that stack equals acc_stack_i.
- R4: Each score saturates at 65535 and never wraps.
- R5: While learning, an event opens a new instance if it is the first event since start or its ID differs from the previous event's ID, whether or not it matched an entry. When a new instance arrives and the instance count already equals inst_limit_i, learning ends on that edge and that event is not scored. Otherwise the count grows by one.
- R6: Events that arrive while not learning change no score, no choice and no interrupt.
- R7: When learning ends, each entry's choice is latched as the mapping with the highest score, with ties going to the lowest mapping index. reg_map_o combinationally shows the choice of entry reg_addr_i.
- R8: irq_o rises on the edge where learning ends and holds until an irq_clr_i pulse. If a set and a clear fall on the same edge, the set wins.
- R9: start_i clears all scores, the instance count, all choices and irq_o, and enters learning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a learning phase |
| tbl_we_i | input | 1 | Allocation table write strobe |
| tbl_idx_i | input | 3 | Table entry index |
| tbl_base_i | input | 32 | Allocation base address |
| tbl_size_i | input | 32 | Allocation size in bytes (0 = unused) |
| inst_limit_i | input | 16 | Number of region instances to learn from |
| acc_valid_i | input | 1 | Access event valid |
| acc_inst_i | input | 16 | Region instance ID |
| acc_addr_i | input | 32 | Access address |
| acc_stack_i | input | 2 | Stack of the issuing code |
| irq_clr_i | input | 1 | Interrupt clear pulse |
| reg_addr_i | input | 3 | Entry index for choice readback |
| reg_map_o | output | 2 | Chosen mapping of entry reg_addr_i |
| learning_o | output | 1 | Learning phase active |
| irq_o | output | 1 | Learning complete interrupt |

## Verification
On every cycle, the assertions check the following: a matched offset lies inside the selected entry, scores neither wrap nor move outside the learning window, and the interrupt holds until it is cleared and always accompanies the end of learning. The bench scenarios cover the behaviour that only shows up at the end of a phase. This includes the argmax with lowest-index tie break, priority among overlapping ranges, the exact event that closes the phase under a given limit, and saturation after more than 65535 matches. Those are checked by reading the latched choices against a bench model of the scores.

// File: rtl/map_learn_pkg.sv
package map_learn_pkg;
  localparam int unsigned MAP_LSB = 12;
  typedef enum logic [0:0] {PH_IDLE = 1'b0, PH_LEARN = 1'b1} phase_e;
endpackage

// File: rtl/alloc_match.sv
module alloc_match #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i [N],
  input  logic [AW-1:0] size_i [N],
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] off_o
);
  logic [N-1:0]  in_rng;
  logic [AW-1:0] rel [N];

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign rel[i]    = addr_i - base_i[i];
    assign in_rng[i] = (addr_i >= base_i[i]) && (rel[i] < size_i[i]);
  end

  // lowest index wins on overlap
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    off_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (in_rng[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
        off_o = rel[i];
      end
    end
  end

  assert_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (off_o < size_i[idx_o]) && (addr_i >= base_i[idx_o]));
endmodule

// File: rtl/score_bank.sv
module score_bank #(
  parameter int unsigned N       = 8,
  parameter int unsigned NM      = 4,
  parameter int unsigned CW      = 16,
  parameter int unsigned AW      = 32,
  parameter int unsigned SW      = 2,
  parameter int unsigned MAP_LSB = 12,
  localparam int unsigned IW     = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [AW-1:0] off_i,
  input  logic [SW-1:0] stack_i,
  output logic [CW-1:0] cnt_o [N][NM]
);
  localparam logic [CW-1:0] CMAX = '1;

  for (genvar i = 0; i < N; i++) begin : g_alloc
    for (genvar m = 0; m < NM; m++) begin : g_map
      logic match;
      assign match = en_i && (idx_i == IW'(i)) &&
                     (off_i[MAP_LSB+m +: SW] == stack_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          cnt_o[i][m] <= '0;
        else if (clr_i)                       cnt_o[i][m] <= '0;
        else if (match && cnt_o[i][m] != CMAX) cnt_o[i][m] <= cnt_o[i][m] + 1'b1;
      end

      assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o[i][m] == CMAX && !clr_i) |=> cnt_o[i][m] == CMAX);
      assert_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !clr_i) |=> $stable(cnt_o[i][m]));
    end
  end
endmodule

// File: rtl/best_pick.sv
module best_pick #(
  parameter int unsigned NM = 4,
  parameter int unsigned CW = 16,
  localparam int unsigned MW = $clog2(NM)
) (
  input  logic [CW-1:0] cnt_i [NM],
  output logic [MW-1:0] sel_o
);
  logic [CW-1:0] best;
  // strict compare keeps the lowest index on ties
  always_comb begin
    sel_o = '0;
    best  = cnt_i[0];
    for (int m = 1; m < NM; m++) begin
      if (cnt_i[m] > best) begin
        best  = cnt_i[m];
        sel_o = MW'(m);
      end
    end
  end
endmodule

// File: rtl/map_learn_analyzer.sv
module map_learn_analyzer
  import map_learn_pkg::*;
#(
  parameter int unsigned N_ALLOC = 8,
  parameter int unsigned N_MAP   = 4,
  parameter int unsigned AW      = 32,
  parameter int unsigned SW      = 2,
  parameter int unsigned CW      = 16,
  parameter int unsigned INST_W  = 16,
  localparam int unsigned IW     = $clog2(N_ALLOC),
  localparam int unsigned MW     = $clog2(N_MAP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tbl_we_i,
  input  logic [IW-1:0]     tbl_idx_i,
  input  logic [AW-1:0]     tbl_base_i,
  input  logic [AW-1:0]     tbl_size_i,
  input  logic [INST_W-1:0] inst_limit_i,
  input  logic              acc_valid_i,
  input  logic [INST_W-1:0] acc_inst_i,
  input  logic [AW-1:0]     acc_addr_i,
  input  logic [SW-1:0]     acc_stack_i,
  input  logic              irq_clr_i,
  input  logic [IW-1:0]     reg_addr_i,
  output logic [MW-1:0]     reg_map_o,
  output logic              learning_o,
  output logic              irq_o
);
  phase_e              phase_q;
  logic                irq_q, seen_q;
  logic [INST_W-1:0]   inst_cnt_q, last_id_q;
  logic [AW-1:0]       base_q [N_ALLOC];
  logic [AW-1:0]       size_q [N_ALLOC];
  logic [MW-1:0]       choice_q [N_ALLOC];
  logic [MW-1:0]       pick [N_ALLOC];
  logic [CW-1:0]       cnt [N_ALLOC][N_MAP];
  logic                hit, ev, new_inst, finish, score_en;
  logic [IW-1:0]       hit_idx;
  logic [AW-1:0]       hit_off;

  assign ev       = acc_valid_i && (phase_q == PH_LEARN) && !start_i;
  assign new_inst = ev && (!seen_q || acc_inst_i != last_id_q);
  assign finish   = new_inst && (inst_cnt_q == inst_limit_i);
  assign score_en = ev && !finish && hit;

  alloc_match #(.N(N_ALLOC), .AW(AW)) u_match (
    .clk_i, .rst_ni, .base_i(base_q), .size_i(size_q), .addr_i(acc_addr_i),
    .hit_o(hit), .idx_o(hit_idx), .off_o(hit_off)
  );

  score_bank #(.N(N_ALLOC), .NM(N_MAP), .CW(CW), .AW(AW), .SW(SW),
               .MAP_LSB(MAP_LSB)) u_score (
    .clk_i, .rst_ni, .clr_i(start_i), .en_i(score_en), .idx_i(hit_idx),
    .off_i(hit_off), .stack_i(acc_stack_i), .cnt_o(cnt)
  );

  for (genvar i = 0; i < N_ALLOC; i++) begin : g_pick
    best_pick #(.NM(N_MAP), .CW(CW)) u_pick (.cnt_i(cnt[i]), .sel_o(pick[i]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[i]   <= '0;
        size_q[i]   <= '0;
        choice_q[i] <= '0;
      end else begin
        if (tbl_we_i && tbl_idx_i == IW'(i)) begin
          base_q[i] <= tbl_base_i;
          size_q[i] <= tbl_size_i;
        end
        if (start_i)     choice_q[i] <= '0;
        else if (finish) choice_q[i] <= pick[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      irq_q      <= 1'b0;
      seen_q     <= 1'b0;
      inst_cnt_q <= '0;
      last_id_q  <= '0;
    end else if (start_i) begin
      phase_q    <= PH_LEARN;
      irq_q      <= 1'b0;
      seen_q     <= 1'b0;
      inst_cnt_q <= '0;
    end else begin
      if (finish) begin
        phase_q <= PH_IDLE;
        irq_q   <= 1'b1;
      end else begin
        if (irq_clr_i) irq_q <= 1'b0;
        if (ev) begin
          seen_q    <= 1'b1;
          last_id_q <= acc_inst_i;
          if (new_inst) inst_cnt_q <= inst_cnt_q + 1'b1;
        end
      end
    end
  end

  assign reg_map_o  = choice_q[reg_addr_i];
  assign learning_o = (phase_q == PH_LEARN);
  assign irq_o      = irq_q;

  assert_irq_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i && !start_i) |=> irq_q);
  assert_end_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(learning_o) |-> irq_o);
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !start_i) |=> $stable(inst_cnt_q) && phase_q == PH_IDLE);
  assert_choice_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !start_i) |=> $stable(choice_q[0]));
endmodule

// File: tb/sim_map_learn_analyzer.sv
`timescale 1ns/1ps
module sim_map_learn_analyzer;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, tbl_we = 0, acc_valid = 0, irq_clr = 0;
  logic [2:0]  tbl_idx = 0, reg_addr = 0;
  logic [31:0] tbl_base = 0, tbl_size = 0, acc_addr = 0;
  logic [15:0] inst_limit = 0, acc_inst = 0;
  logic [1:0]  acc_stack = 0;
  logic [1:0]  reg_map;
  logic        learning, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  longint m_base [8];
  longint m_size [8];
  int     m_cnt [8][4];
  int     m_choice [8];
  bit     m_learn, m_irq, m_seen;
  int     m_inst, m_last, m_limit;

  always #10 clk = ~clk;

  map_learn_analyzer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tbl_we_i(tbl_we),
    .tbl_idx_i(tbl_idx), .tbl_base_i(tbl_base), .tbl_size_i(tbl_size),
    .inst_limit_i(inst_limit), .acc_valid_i(acc_valid), .acc_inst_i(acc_inst),
    .acc_addr_i(acc_addr), .acc_stack_i(acc_stack), .irq_clr_i(irq_clr),
    .reg_addr_i(reg_addr), .reg_map_o(reg_map), .learning_o(learning), .irq_o(irq)
  );

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int argmax(int i);
    int b = 0;
    for (int m = 1; m < 4; m++) if (m_cnt[i][m] > m_cnt[i][b]) b = m;
    return b;
  endfunction

  task automatic load(int i, longint base, longint size);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 3'(i); tbl_base = 32'(base); tbl_size = 32'(size);
    m_base[i] = base; m_size[i] = size;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic do_start(int limit);
    @(negedge clk);
    start = 1; inst_limit = 16'(limit);
    m_limit = limit; m_learn = 1; m_irq = 0; m_seen = 0; m_inst = 0;
    for (int i = 0; i < 8; i++) begin
      m_choice[i] = 0;
      for (int m = 0; m < 4; m++) m_cnt[i][m] = 0;
    end
    @(negedge clk);
    start = 0;
  endtask

  task automatic send(int id, longint addr, int stk);
    bit nw;
    int hit;
    longint off;
    @(negedge clk);
    acc_valid = 1; acc_inst = 16'(id); acc_addr = 32'(addr); acc_stack = 2'(stk);
    if (m_learn) begin
      nw = !m_seen || id != m_last;
      if (nw && m_inst == m_limit) begin
        m_learn = 0; m_irq = 1;
        for (int i = 0; i < 8; i++) m_choice[i] = argmax(i);
      end else begin
        m_seen = 1; m_last = id;
        if (nw) m_inst++;
        hit = -1;
        for (int i = 7; i >= 0; i--)
          if (addr >= m_base[i] && addr - m_base[i] < m_size[i]) hit = i;
        if (hit >= 0) begin
          off = addr - m_base[hit];
          for (int m = 0; m < 4; m++)
            if (((off >> (12 + m)) & 3) == stk && m_cnt[hit][m] < 65535)
              m_cnt[hit][m]++;
        end
      end
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic check_choices(string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      reg_addr = 3'(i);
      #1 check(req, reg_map, m_choice[i]);
    end
  endtask

  // random phase: each entry biased toward mapping (i+rot)%4
  task automatic rand_phase(int limit, int rot);
    int id = 1, guard = 0;
    longint off, a;
    int e, t, s;
    do_start(limit);
    while (m_learn && guard < 3000) begin
      if ($urandom_range(3) == 0) id++;
      e = $urandom_range(8);
      off = longint'($urandom_range(32'h1FFFF));
      a = 64'h100000 + longint'(e) * 64'h40000 + off;
      t = (e + rot) % 4;
      s = ($urandom_range(3) != 0) ? int'((off >> (12 + t)) & 3) : int'($urandom_range(3));
      send(id, a, s);
      guard++;
    end
    idle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_learn = 0; m_irq = 0; m_seen = 0; m_inst = 0; m_limit = 0; m_last = 0;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_choice[i] = 0;
      for (int m = 0; m < 4; m++) m_cnt[i][m] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    check("R1 learning", learning, 0);
    check("R1 irq", irq, 0);
    check("R1 map", reg_map, 0);
    rst_n = 1;

    // R2/R3 table: entries 0..5, entry 5 overlaps entry 2, 6 and 7 unused
    for (int i = 0; i < 6; i++) load(i, 64'h100000 + longint'(i) * 64'h40000, 64'h20000);
    load(5, 64'h100000 + 2 * 64'h40000, 64'h20000);
    load(6, 64'h300000, 0);
    load(7, 64'h340000, 0);

    // R5 limit 0: first event ends phase, unscored
    do_start(0);
    check("R9 learning after start", learning, 1);
    send(7, 64'h100000, 0);
    idle();
    check("R5 limit0 ends", learning, 0);
    check("R8 irq set", irq, 1);
    check_choices("R7 limit0 choices");

    // R8 hold then clear
    repeat (5) @(negedge clk);
    check("R8 irq held", irq, 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check("R8 irq cleared", irq, 0);

    // R6 events while idle: no irq, choices unchanged
    for (int k = 0; k < 10; k++) send(k + 50, 64'h100000 + longint'(k) * 64'h1000, 1);
    idle();
    check("R6 no irq when idle", irq, 0);
    check("R6 still idle", learning, 0);
    check_choices("R6 choices untouched");

    // directed biased scenarios, R2 overlap and R3 mapping bits
    rand_phase(12, 0);
    check("R8 irq after phase", irq, 1);
    check("R5 learning ended", learning, 0);
    check_choices("R3 R7 biased rot0");
    rand_phase(25, 3);
    check_choices("R2 R7 biased rot3");
    rand_phase(40, 1);
    check_choices("R7 biased rot1");

    // R5 exact boundary: limit 2, two instances scored, third ends
    do_start(2);
    send(1, 64'h100000 + 64'h2000, 2);
    send(2, 64'h100000 + 64'h2000, 2);
    send(2, 64'h100000 + 64'h2000, 2);
    idle();
    check("R5 still learning at limit", learning, 1);
    send(3, 64'h100000 + 64'h6000, 3);
    send(3, 64'h100000 + 64'h6000, 3);
    idle();
    check("R5 ended on new instance", learning, 0);
    check_choices("R5 scoring stopped");

    // R8 set wins over clear in same cycle
    do_start(0);
    @(negedge clk);
    irq_clr = 1; acc_valid = 1; acc_inst = 9; acc_addr = 32'h100000; acc_stack = 0;
    @(negedge clk);
    irq_clr = 0; acc_valid = 0;
    m_learn = 0; m_irq = 1;
    check("R8 set beats clear", irq, 1);

    // R9 start clears irq and choices
    do_start(5);
    check("R9 irq cleared by start", irq, 0);
    check_choices("R9 choices cleared");

    // R4 saturation: all four scores hit the cap, then mapping 1 only
    for (int k = 0; k < 65540; k++) send(1, 64'h100000, 0);
    for (int k = 0; k < 5; k++) send(1, 64'h100000 + 64'h6000, 3);
    send(2, 64'h100000, 0);
    send(3, 64'h100000, 0);
    send(4, 64'h100000, 0);
    send(5, 64'h100000, 0);
    send(6, 64'h100000, 0);
    idle();
    check("R4 phase ended", learning, 0);
    check_choices("R4 saturated tie");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule